// File: doc/BRIEF.md
# Clocked synchronous serial transceiver

This block moves 8-bit characters over a three-wire synchronous link: one serial clock, one data output and one data input. The transmitter and the receiver are separate units that share the serial clock, so a byte can go out while another comes in. Bits travel least significant first. There is no parity bit and no extra framing bit. Outgoing data changes when the serial clock falls. Incoming data is captured when the serial clock rises. Between characters the clock rests high, and the data output keeps the last bit it sent.

The serial clock comes from one of two sources. It can be made inside the block from the system clock by a programmable divider, in which case the block drives it out. It can also be taken from outside through a two-flop synchronizer, in which case the block's clock driver is released.

Each direction has a one-byte holding register in front of its shift register. Software can load the next byte, or read the last one, while a character is still moving. When a byte is already waiting as a character ends, the next character follows with no idle clock period between them.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the transmit-empty and transmit-end flags are 1, the receive-full and overrun flags are 0, and both `sck_o` and `sd_o` are 1.
- R2: Each transmitted character is the 8 bits of the written byte, bit 0 first. `sd_o` changes only in the system-clock cycle in which `sck_o` falls, and it holds its value until the next fall.
- R3: With `cfg_ext_clk` = 0, `sck_oe` is 1. Every low phase of `sck_o` lasts `cfg_div`+1 system clocks. Every high phase inside a run of back-to-back characters also lasts `cfg_div`+1 system clocks.
- R4: With the internal clock, `sck_o` gives exactly 8 pulses per character and stays high whenever no character is being sent.
- R5: After the last bit of a character, `sd_o` keeps the value of bit 7 until the next character starts.
- R6: `st_tx_empty` returns to 1 when the held byte moves into the shift register. A write while `st_tx_empty` is 0 is ignored. If a byte is held when a character ends, the next character starts with no extra clock gap.
- R7: `st_tx_end` is 1 exactly when the shift register is idle and no byte is held.
- R8: The receiver samples `sd_i` on each rising serial-clock edge, bit 0 first. After 8 bits the byte appears on `rx_rdata` and `st_rx_full` goes to 1. A one-cycle `rx_rd` pulse clears `st_rx_full`.
- R9: When a byte completes while `st_rx_full` is 1 (and `rx_rd` is not asserted in that cycle), the new byte is discarded, `rx_rdata` keeps the old byte, and `st_overrun` goes to 1. A one-cycle `ovr_clr` pulse clears `st_overrun`.
- R10: With `cfg_ext_clk` = 1, `sck_oe` is 0 and `sck_o` stays 1. The transmitter shifts on the synchronized falling edges of `sck_i`. The receiver samples on its rising edges. Falling edges that arrive while nothing is being sent leave `sd_o` unchanged.
- R11: Transmission and reception run at the same time on the same serial clock, and each direction keeps its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ext_clk | input | 1 | 1 = serial clock from `sck_i`, 0 = internal divider |
| cfg_div | input | DIV_W | Divider value N; one bit lasts 2×(N+1) system clocks |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | CHAR_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe; clears receive-full |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_rdata | output | CHAR_W | Last received byte |
| st_tx_empty | output | 1 | Transmit holding register can take a byte |
| st_tx_end | output | 1 | Transmitter fully idle |
| st_rx_full | output | 1 | Unread byte in `rx_rdata` |
| st_overrun | output | 1 | A byte was lost because the previous one was unread |
| sck_i | input | 1 | External serial clock |
| sck_o | output | 1 | Internal serial clock output |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |

## Verification
The bench uses the default widths (8-bit divider, 8-bit characters). It runs divider values 0, 1, 2, 3 and 7 with `sd_o` looped back to `sd_i`. The value 0 gives the tightest case: one-cycle clock phases, where the reload of the holding register at the last rising edge must still keep the character stream gapless. Sweeping byte pairs, including all-zero, all-one and alternating patterns, checks bit order, pulse count, phase lengths and MSB hold against values computed from the divider. A separate run drives an external clock at eight system clocks per bit, close to the synchronizer limit, and adds idle pulses after the transmitter has emptied.

// File: rtl/sxr_pkg.sv
package sxr_pkg;
  // one-cycle strobes marking serial clock transitions in the system domain
  typedef struct packed {
    logic fall;
    logic rise;
  } sck_evt_t;
endpackage

// File: rtl/sxr_clkgen.sv
module sxr_clkgen
  import sxr_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] div,
  input  logic             run,
  input  logic             sck_in,
  input  logic             sd_in,
  output logic             sck_out,
  output logic             sd_sample,
  output sck_evt_t         evt
);
  logic [DIV_W-1:0] cnt;
  logic             active;
  logic             sck_q;
  logic [2:0]       sck_sync;
  logic [1:0]       sd_sync;
  logic             terminal;

  assign terminal = (cnt == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      active   <= 1'b0;
      sck_q    <= 1'b1;
      sck_sync <= 3'b111;
      sd_sync  <= 2'b11;
    end else begin
      sck_sync <= {sck_sync[1:0], sck_in};
      sd_sync  <= {sd_sync[0], sd_in};
      if (ext_mode) begin
        active <= 1'b0;
        sck_q  <= 1'b1;
        cnt    <= '0;
      end else if (!active) begin
        if (run) begin
          active <= 1'b1;
          sck_q  <= 1'b0;
          cnt    <= '0;
        end
      end else if (terminal) begin
        cnt <= '0;
        if (!sck_q)   sck_q  <= 1'b1;
        else if (run) sck_q  <= 1'b0;
        else          active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (ext_mode) begin
      evt.fall = sck_sync[2] & ~sck_sync[1];
      evt.rise = ~sck_sync[2] & sck_sync[1];
    end else begin
      evt.fall = (~active & run) | (active & terminal & sck_q & run);
      evt.rise = active & terminal & ~sck_q;
    end
  end

  // in external mode data is delayed like the clock so the two stay aligned
  assign sd_sample = ext_mode ? sd_sync[1] : sd_in;
  assign sck_out   = sck_q;
endmodule

// File: rtl/sxr_tx.sv
module sxr_tx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              fall,
  input  logic              rise,
  output logic              sd,
  output logic              busy,
  output logic              hold_full
);
  localparam int CNT_W = $clog2(CHAR_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W);

  logic [CHAR_W-1:0] hold_q;
  logic [CHAR_W-1:0] shift_q;
  logic [CNT_W-1:0]  bits_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      shift_q   <= '0;
      bits_q    <= '0;
      hold_full <= 1'b0;
      busy      <= 1'b0;
      sd        <= 1'b1;
    end else begin
      if (wr && !hold_full) begin
        hold_q    <= wdata;
        hold_full <= 1'b1;
      end
      if (!busy) begin
        if (hold_full) begin
          shift_q   <= hold_q;
          hold_full <= 1'b0;
          busy      <= 1'b1;
          bits_q    <= '0;
        end
      end else begin
        if (fall && bits_q != LAST) begin
          sd      <= shift_q[0];
          shift_q <= shift_q >> 1;
          bits_q  <= bits_q + 1'b1;
        end
        if (rise && bits_q == LAST) begin
          if (hold_full) begin
            shift_q   <= hold_q;
            hold_full <= 1'b0;
            bits_q    <= '0;
          end else begin
            busy <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sxr_rx.sv
module sxr_rx #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              sd,
  input  logic              rd,
  input  logic              ovr_clr,
  output logic [CHAR_W-1:0] data,
  output logic              full,
  output logic              ovr
);
  localparam int CNT_W = $clog2(CHAR_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

  logic [CHAR_W-1:0] shift_q;
  logic [CNT_W-1:0]  bits_q;
  logic [CHAR_W-1:0] next_shift;

  assign next_shift = {sd, shift_q[CHAR_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      bits_q  <= '0;
      data    <= '0;
      full    <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (rd)      full <= 1'b0;
      if (ovr_clr) ovr  <= 1'b0;
      if (rise) begin
        shift_q <= next_shift;
        if (bits_q == LAST) begin
          bits_q <= '0;
          if (full && !rd) begin
            ovr <= 1'b1;
          end else begin
            data <= next_shift;
            full <= 1'b1;
          end
        end else begin
          bits_q <= bits_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sxr_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_ext_clk,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              tx_wr,
  input  logic [CHAR_W-1:0] tx_wdata,
  input  logic              rx_rd,
  input  logic              ovr_clr,
  output logic [CHAR_W-1:0] rx_rdata,
  output logic              st_tx_empty,
  output logic              st_tx_end,
  output logic              st_rx_full,
  output logic              st_overrun,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sd_i,
  output logic              sd_o
);
  sck_evt_t evt;
  logic     tx_busy;
  logic     tx_hold_full;
  logic     sd_sample;
  logic     oe_q;

  sxr_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk      (clk),
    .rst      (rst),
    .ext_mode (cfg_ext_clk),
    .div      (cfg_div),
    .run      (tx_busy),
    .sck_in   (sck_i),
    .sd_in    (sd_i),
    .sck_out  (sck_o),
    .sd_sample(sd_sample),
    .evt      (evt)
  );

  sxr_tx #(.CHAR_W(CHAR_W)) i_tx (
    .clk      (clk),
    .rst      (rst),
    .wr       (tx_wr),
    .wdata    (tx_wdata),
    .fall     (evt.fall),
    .rise     (evt.rise),
    .sd       (sd_o),
    .busy     (tx_busy),
    .hold_full(tx_hold_full)
  );

  sxr_rx #(.CHAR_W(CHAR_W)) i_rx (
    .clk    (clk),
    .rst    (rst),
    .rise   (evt.rise),
    .sd     (sd_sample),
    .rd     (rx_rd),
    .ovr_clr(ovr_clr),
    .data   (rx_rdata),
    .full   (st_rx_full),
    .ovr    (st_overrun)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b1;
    else     oe_q <= ~cfg_ext_clk;
  end

  assign sck_oe      = oe_q;
  assign st_tx_empty = ~tx_hold_full;
  assign st_tx_end   = ~tx_busy & ~tx_hold_full;
endmodule

// File: rtl/sxr_checker.sv
module sxr_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_ext_clk,
  input logic              rx_rd,
  input logic [CHAR_W-1:0] rx_rdata,
  input logic              st_tx_end,
  input logic              st_rx_full,
  input logic              st_overrun,
  input logic              sck_o,
  input logic              sd_o
);
  AST_SD_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!cfg_ext_clk && !$stable(sd_o)) |-> !sck_o); // R2
  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st_tx_end && $past(st_tx_end) && !cfg_ext_clk) |-> sck_o); // R4
  AST_MSB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_tx_end && $past(st_tx_end)) |-> $stable(sd_o)); // R5
  AST_RX_DATA_KEPT: assert property (@(posedge clk) disable iff (rst)
    (st_rx_full && $past(st_rx_full) && !$past(rx_rd)) |-> $stable(rx_rdata)); // R9
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (rst)
    $rose(st_overrun) |-> $past(st_rx_full)); // R9
endmodule

bind sync_serial_xcvr sxr_checker #(.CHAR_W(CHAR_W)) i_sxr_checker (
  .clk        (clk),
  .rst        (rst),
  .cfg_ext_clk(cfg_ext_clk),
  .rx_rd      (rx_rd),
  .rx_rdata   (rx_rdata),
  .st_tx_end  (st_tx_end),
  .st_rx_full (st_rx_full),
  .st_overrun (st_overrun),
  .sck_o      (sck_o),
  .sd_o       (sd_o)
);

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W  = 8;
  localparam int CHAR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_ext_clk = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic tx_wr = 1'b0;
  logic [CHAR_W-1:0] tx_wdata = '0;
  logic rx_rd = 1'b0;
  logic ovr_clr = 1'b0;
  logic [CHAR_W-1:0] rx_rdata;
  logic st_tx_empty, st_tx_end, st_rx_full, st_overrun;
  logic sck_i = 1'b1;
  logic sck_o, sck_oe, sd_o;
  logic loop = 1'b1;
  logic drv_sd = 1'b1;
  logic sd_i;

  assign sd_i = loop ? sd_o : drv_sd;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_serial_xcvr #(.DIV_W(DIV_W), .CHAR_W(CHAR_W)) i_sync_serial_xcvr (
    .clk(clk), .rst(rst), .cfg_ext_clk(cfg_ext_clk), .cfg_div(cfg_div),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .ovr_clr(ovr_clr),
    .rx_rdata(rx_rdata), .st_tx_empty(st_tx_empty), .st_tx_end(st_tx_end),
    .st_rx_full(st_rx_full), .st_overrun(st_overrun), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe(sck_oe), .sd_i(sd_i), .sd_o(sd_o)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // serial clock monitor, internal mode
  bit          mon_en = 0;
  int          mon_n = 0;
  logic        prev_sck = 1'b1;
  int          hold_len = 0;
  int          rises = 0;
  int          falls = 0;
  int          phase_err = 0;
  logic [63:0] cap = '0;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (mon_en) begin
      if (sck_o != prev_sck) begin
        if (sck_o) begin
          if (hold_len != mon_n + 1) phase_err++;
          if (rises < 64) cap[rises] = sd_o;
          rises++;
        end else begin
          if (falls > 0 && hold_len != mon_n + 1) phase_err++;
          falls++;
        end
        hold_len = 1;
      end else begin
        hold_len++;
      end
      prev_sck = sck_o;
    end
  end

  task automatic do_reset(input int n, input logic ext);
    @(negedge clk);
    rst = 1'b1; cfg_div = DIV_W'(n); cfg_ext_clk = ext;
    mon_en = 0; mon_n = n; prev_sck = 1'b1; hold_len = 0;
    rises = 0; falls = 0; phase_err = 0; cap = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mon_en = 1;
  endtask

  task automatic wr_byte(input logic [7:0] v);
    tx_wr = 1'b1; tx_wdata = v;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic wait_empty();
    while (!st_tx_empty) @(negedge clk);
  endtask

  task automatic read_expect(input logic [7:0] exp, input string tag);
    while (!st_rx_full) @(negedge clk);
    check(rx_rdata == exp, tag, rx_rdata, exp);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic run_int(input int n, input logic [7:0] b0, input logic [7:0] b1);
    do_reset(n, 1'b0);
    loop = 1'b1;
    fork
      begin
        wr_byte(b0);
        wait_empty();
        wr_byte(b1);
        while (rises < 16) @(negedge clk);
      end
      begin
        read_expect(b0, "R8 R11 loopback byte0");
        read_expect(b1, "R8 R11 loopback byte1");
      end
    join
    repeat (3*(n+1) + 6) @(negedge clk);
    check(rises == 16, "R4 pulse count", rises, 16);
    check(falls == 16, "R4 fall count", falls, 16);
    check(phase_err == 0, "R3 R6 phase length gapless", phase_err, 0);
    check(cap[15:0] == {b1, b0}, "R2 LSB first bits", cap[15:0], {b1, b0});
    check(sd_o == b1[7], "R5 msb hold", sd_o, b1[7]);
    check(sck_o == 1'b1, "R4 idle high", sck_o, 1);
    check(st_tx_end == 1'b1, "R7 tx end", st_tx_end, 1);
    check(sck_oe == 1'b1, "R3 drive enable", sck_oe, 1);
  endtask

  task automatic ext_bit(input logic d, inout logic [63:0] got, input int idx);
    sck_i = 1'b0; drv_sd = d;
    repeat (4) @(negedge clk);
    got[idx] = sd_o;
    sck_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [63:0] got;
    logic [7:0]  r0, r1, r2, t0, t1;
    logic        hold_v;
    int          ns[5];
    ns = '{0, 1, 2, 3, 7};

    // R1 reset state
    do_reset(0, 1'b0);
    check(st_tx_empty == 1'b1, "R1 tx empty", st_tx_empty, 1);
    check(st_tx_end == 1'b1, "R1 R7 tx end", st_tx_end, 1);
    check(st_rx_full == 1'b0, "R1 rx full", st_rx_full, 0);
    check(st_overrun == 1'b0, "R1 overrun", st_overrun, 0);
    check(sck_o == 1'b1, "R1 sck", sck_o, 1);
    check(sd_o == 1'b1, "R1 sd", sd_o, 1);

    // internal clock sweep, loopback, back-to-back pairs
    foreach (ns[i]) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] a, b;
        case (k)
          0: begin a = 8'h00; b = 8'hFF; end
          1: begin a = 8'hFF; b = 8'h00; end
          2: begin a = 8'h55; b = 8'hAA; end
          default: begin a = 8'((ns[i]*53 + 29) & 255); b = a ^ 8'h96; end
        endcase
        run_int(ns[i], a, b);
      end
    end

    // R6 R9 write while full ignored, overrun keeps first byte
    do_reset(1, 1'b0);
    loop = 1'b1;
    wr_byte(8'h3C);
    wait_empty();
    wr_byte(8'hC5);
    check(st_tx_empty == 1'b0, "R6 buffer full", st_tx_empty, 0);
    wr_byte(8'h7E);
    while (rises < 16) @(negedge clk);
    repeat (20) @(negedge clk);
    check(rises == 16, "R6 ignored write adds no char", rises, 16);
    check(cap[15:0] == 16'hC53C, "R6 sent bytes", cap[15:0], 16'hC53C);
    check(st_rx_full == 1'b1, "R8 full", st_rx_full, 1);
    check(rx_rdata == 8'h3C, "R9 old byte kept", rx_rdata, 8'h3C);
    check(st_overrun == 1'b1, "R9 overrun set", st_overrun, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    check(st_overrun == 1'b0, "R9 overrun cleared", st_overrun, 0);
    check(st_rx_full == 1'b1, "R9 full unaffected by clear", st_rx_full, 1);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    check(st_rx_full == 1'b0, "R8 read clears full", st_rx_full, 0);

    // R10 R11 external clock, full duplex, idle falls ignored
    do_reset(0, 1'b1);
    loop = 1'b0;
    t0 = 8'hB4; t1 = 8'h2D; r0 = 8'h96; r1 = 8'h71; r2 = 8'hE8;
    got = '0;
    wr_byte(t0);
    wait_empty();
    wr_byte(t1);
    @(negedge clk);
    check(sck_oe == 1'b0, "R10 released clock", sck_oe, 0);
    fork
      begin
        for (int b = 0; b < 16; b++)
          ext_bit(b < 8 ? r0[b] : r1[b-8], got, b);
        hold_v = sd_o;
        for (int b = 0; b < 8; b++)
          ext_bit(r2[b], got, 16 + b);
      end
      begin
        read_expect(r0, "R10 R11 ext rx byte0");
        read_expect(r1, "R10 R11 ext rx byte1");
        read_expect(r2, "R10 ext rx byte2");
      end
    join
    check(got[15:0] == {t1, t0}, "R10 R2 ext tx bits", got[15:0], {t1, t0});
    check(hold_v == t1[7], "R5 ext msb hold", hold_v, t1[7]);
    check(got[23:16] == {8{t1[7]}}, "R10 idle falls ignored", got[23:16], {8{t1[7]}});
    check(sck_o == 1'b1, "R10 sck_o high", sck_o, 1);
    check(st_tx_end == 1'b1, "R7 ext tx end", st_tx_end, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule